// File: doc/BRIEF.md
# Keyed-Sequence Hardware Watchdog Timer

This block is a recovery watchdog for a small 8-bit microcontroller. It listens to the special-function-register write bus through an address, a data byte and a write strobe. It stays dormant after reset until software writes a two-byte unlock key to one write-only key register. From then on it counts machine-cycle ticks. Software must repeat the same two-byte key before the count runs out. If it does not, the block drives a reset request low for a fixed number of clock cycles.

Once started, software cannot stop the watchdog. Only a hardware reset, or the reset pulse that the watchdog produces itself, returns it to the dormant state. A 3-bit prescaler select stretches the time-out by a power of two. The counter and the prescaler cannot be read or written over the bus.

Top module: `keyed_wdt`

## Requirements
- R1: After rst_n is released, rst_req_n is high and the watchdog is dormant: ticks alone never make rst_req_n go low.
- R2: The watchdog starts only when, at key address A6h, a write of 1Eh is followed by a write of E1h. Writes to other addresses between them do not break the pair. A repeated 1Eh still leaves the tracker waiting for E1h.
- R3: Any byte other than 1Eh or E1h written to A6h returns the key tracker to idle, so a later E1h neither starts nor services the watchdog. An E1h with no 1Eh before it is ignored.
- R4: An accepted key pair clears the tick counter and the prescaler. The time-out is then measured from that write, and a tick in the same cycle as the write is discarded.
- R5: With prescaler select 0, rst_req_n goes low in the cycle after the clock edge that samples the 16383rd tick since the last accepted key pair. Cycles without a tick do not advance the count.
- R6: A prescaler select value N (0 to 7) makes the time-out 16383 × 2^N ticks.
- R7: The reset request stays low for exactly 96 clock cycles and then returns high.
- R8: Bus writes made while the reset request is low have no effect. After the pulse the watchdog is dormant, and its counter, prescaler and key tracker are all cleared.
- R9: Once running, the watchdog cannot be stopped by any bus write. Stray writes, including non-key data at A6h, leave the count running toward the time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick | input | 1 | One-cycle machine-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| pre_sel | input | 3 | Prescaler select N, divide by 2^N |
| rst_req_n | output | 1 | Active-low reset request pulse |

## Verification
The assertions assume that the bus inputs are synchronous to clk and settle well before each rising edge. They also assume that the strobe, address and data are valid together in the one cycle that makes up a write. The bench meets this by driving every input only on the falling edge. It holds pre_sel steady while a time-out is measured, because the expected tick count is derived from a single select value. Its random bus traffic never places 1Eh or E1h at the key address, so no unintended service can occur.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_COUNT = 2'd1,
    WD_PULSE = 2'd2
  } wd_mode_t;

  typedef enum logic {
    KEY_WAIT_LO = 1'b0,
    KEY_WAIT_HI = 1'b1
  } key_state_t;

endpackage

// File: rtl/wdt_key_tracker.sv
module wdt_key_tracker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_LO   = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_HI   = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_ok
);
  import wdt_pkg::*;

  key_state_t state_q, state_d;
  logic       key_wr;

  assign key_wr = accept && wr_en && (wr_addr == KEY_ADDR);
  assign key_ok = key_wr && (state_q == KEY_WAIT_HI) && (wr_data == KEY_HI);

  always_comb begin
    state_d = state_q;
    if (!accept) begin
      state_d = KEY_WAIT_LO;
    end else if (key_wr) begin
      if (wr_data == KEY_LO) state_d = KEY_WAIT_HI;
      else                   state_d = KEY_WAIT_LO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_WAIT_LO;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W:0]   mask_wide;
  logic [PRE_W-1:0] mask;
  logic             pre_we;
  logic             wrap;

  assign mask_wide = ((PRE_W+1)'(1) << sel) - (PRE_W+1)'(1);
  assign mask      = mask_wide[PRE_W-1:0];
  assign wrap      = ((pre_q & mask) == mask);
  assign step      = run && tick && !clr && wrap;

  always_comb begin
    pre_we = 1'b0;
    pre_d  = pre_q;
    if (clr || !run) begin
      pre_we = (pre_q != '0);
      pre_d  = '0;
    end else if (tick) begin
      pre_we = 1'b1;
      pre_d  = wrap ? '0 : pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_we) pre_q <= pre_d;
  end

endmodule

// File: rtl/wdt_timeout_core.sv
module wdt_timeout_core #(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_ok,
  input  logic step,
  output logic armed,
  output logic pulsing,
  output logic rst_req_n
);
  import wdt_pkg::*;

  localparam int PULSE_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0]   CNT_LAST  = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [PULSE_W-1:0] PULSE_END = PULSE_W'(PULSE_LEN - 1);

  wd_mode_t           mode_q, mode_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [PULSE_W-1:0] pcnt_q, pcnt_d;
  logic               cnt_we, pcnt_we;
  logic               req_q, req_d;

  always_comb begin
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    cnt_we  = 1'b0;
    pcnt_d  = pcnt_q;
    pcnt_we = 1'b0;
    unique case (mode_q)
      WD_IDLE: begin
        if (key_ok) begin
          mode_d = WD_COUNT;
          cnt_d  = '0;
          cnt_we = 1'b1;
        end
      end
      WD_COUNT: begin
        if (key_ok) begin
          cnt_d  = '0;
          cnt_we = 1'b1;
        end else if (step) begin
          cnt_we = 1'b1;
          if (cnt_q == CNT_LAST) begin
            mode_d  = WD_PULSE;
            cnt_d   = '0;
            pcnt_d  = '0;
            pcnt_we = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      WD_PULSE: begin
        pcnt_we = 1'b1;
        if (pcnt_q == PULSE_END) begin
          mode_d = WD_IDLE;
          pcnt_d = '0;
        end else begin
          pcnt_d = pcnt_q + PULSE_W'(1);
        end
      end
      default: begin
        mode_d = WD_IDLE;
      end
    endcase
    req_d = (mode_d != WD_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WD_IDLE;
      req_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      req_q  <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_we) pcnt_q <= pcnt_d;
  end

  assign armed     = (mode_q == WD_COUNT);
  assign pulsing   = (mode_q == WD_PULSE);
  assign rst_req_n = req_q;

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int SEL_W     = 3,
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_LO   = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_HI   = 8'hE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  pre_sel,
  output logic              rst_req_n
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       key_ok;
  logic       step;
  logic       armed;
  logic       pulsing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  wdt_key_tracker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .KEY_ADDR(KEY_ADDR),
    .KEY_LO  (KEY_LO),
    .KEY_HI  (KEY_HI)
  ) key_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .accept (!pulsing),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .key_ok (key_ok)
  );

  wdt_prescaler #(
    .SEL_W(SEL_W)
  ) pre_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (key_ok),
    .run  (armed),
    .tick (tick),
    .sel  (pre_sel),
    .step (step)
  );

  wdt_timeout_core #(
    .CNT_W    (CNT_W),
    .PULSE_LEN(PULSE_LEN)
  ) core_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .key_ok   (key_ok),
    .step     (step),
    .armed    (armed),
    .pulsing  (pulsing),
    .rst_req_n(rst_req_n)
  );

endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 96,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hA6,
  parameter logic [DATA_W-1:0] KEY_HI   = 8'hE1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_req_n,
  input logic              armed,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam int LW = $clog2(PULSE_LEN + 2);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt_q <= '0;
    else if (!rst_req_n) low_cnt_q <= low_cnt_q + LW'(1);
    else                 low_cnt_q <= '0;
  end

  // R2
  key_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(wr_en && (wr_addr == KEY_ADDR) && (wr_data == KEY_HI)));

  // R5
  fall_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_n) |-> $past(armed));

  // R7
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |-> (low_cnt_q < LW'(PULSE_LEN)));

  // R7
  pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n) |-> ($past(low_cnt_q) == LW'(PULSE_LEN - 1)));

  // R8
  pulse_dormant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req_n |-> !armed);

  // R9
  no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (armed || !rst_req_n));

endmodule

bind keyed_wdt keyed_wdt_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .PULSE_LEN(PULSE_LEN),
  .KEY_ADDR (KEY_ADDR),
  .KEY_HI   (KEY_HI)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_req_n(rst_req_n),
  .armed    (armed),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/1ps
module keyed_wdt_tb_top;

  localparam logic [7:0] KADDR = 8'hA6;
  localparam logic [7:0] KLO   = 8'h1E;
  localparam logic [7:0] KHI   = 8'hE1;
  localparam int         PLEN  = 96;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] pre_sel;
  logic       rst_req_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  keyed_wdt dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pre_sel  (pre_sel),
    .rst_req_n(rst_req_n)
  );

  function automatic int timeout_ticks(input int sel);
    return ((1 << 14) - 1) << sel;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic key_pair();
    wr(KADDR, KLO);
    wr(KADDR, KHI);
  endtask

  task automatic run_ticks(input int limit, input bit rnd, output int ticks, output bit fell);
    ticks = 0;
    fell  = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_req_n) begin fell = 1'b1; break; end
      if (ticks >= limit) break;
      tick  = rnd ? 1'($urandom % 2) : 1'b1;
      wr_en = 1'b0;
      if (rnd && ($urandom % 8 == 0)) begin
        wr_en   = 1'b1;
        wr_addr = 8'($urandom);
        wr_data = 8'($urandom);
        if (wr_addr == KADDR && (wr_data == KLO || wr_data == KHI)) wr_data = 8'h5A;
      end
      @(posedge clk);
      if (tick) ticks++;
    end
    tick  = 1'b0;
    wr_en = 1'b0;
  endtask

  // Called at the negedge where rst_req_n was first seen low.
  task automatic measure_pulse(output int n);
    n = 1;
    while (n < 300) begin
      wr_en = 1'b0;
      if (n == 3) begin wr_en = 1'b1; wr_addr = KADDR; wr_data = KLO; end
      if (n == 4) begin wr_en = 1'b1; wr_addr = KADDR; wr_data = KHI; end
      @(negedge clk);
      if (!rst_req_n) n++;
      else break;
    end
    wr_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 198000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 198000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int  t;
    bit  f;
    int  n;
    int  t0;
    void'($urandom(32'd1234));
    t0 = timeout_ticks(0);
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; pre_sel = '0;
    repeat (5) @(negedge clk);
    chk(rst_req_n == 1'b1, "R1 reset level", int'(rst_req_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rst_req_n == 1'b1, "R1 after release", int'(rst_req_n), 1);

    // R3: wrong order, broken pair, lone high byte
    wr(KADDR, KHI);
    wr(KADDR, KLO);
    wr(KADDR, 8'h55);
    wr(KADDR, KHI);
    run_ticks(16500, 1'b0, t, f);
    chk(!f, "R1 R3 dormant without valid key", int'(f), 0);

    // R2: other-address write between, repeated low byte
    wr(KADDR, KLO);
    wr(8'h80, KHI);
    wr(KADDR, KLO);
    wr(KADDR, KHI);
    run_ticks(t0 + 10, 1'b0, t, f);
    chk(f, "R2 key pair starts watchdog", int'(f), 1);
    chk(t == t0, "R5 time-out tick count sel0", t, t0);
    measure_pulse(n);
    chk(n == PLEN, "R7 pulse length", n, PLEN);
    run_ticks(16500, 1'b0, t, f);
    chk(!f, "R8 dormant after pulse, writes in pulse ignored", int'(f), 0);

    // R4: service restarts time-out
    key_pair();
    run_ticks(8000, 1'b0, t, f);
    chk(!f && t == 8000, "R4 no early reset", t, 8000);
    key_pair();
    run_ticks(t0 + 10, 1'b0, t, f);
    chk(f && t == t0, "R4 time-out from last service", t, t0);
    measure_pulse(n);
    chk(n == PLEN, "R7 pulse length second", n, PLEN);

    // R3 R9: broken service pair does not service
    key_pair();
    run_ticks(5000, 1'b0, t, f);
    wr(KADDR, KLO);
    wr(KADDR, 8'h77);
    wr(KADDR, KHI);
    run_ticks(t0, 1'b0, t, f);
    chk(f && t == t0 - 5000, "R3 R9 broken pair ignored", t, t0 - 5000);
    measure_pulse(n);
    chk(n == PLEN, "R7 pulse length third", n, PLEN);

    // R6 R9: prescaler 1, random ticks and stray writes
    pre_sel = 3'd1;
    key_pair();
    run_ticks(timeout_ticks(1) + 10, 1'b1, t, f);
    chk(f, "R9 random writes do not stop", int'(f), 1);
    chk(t == timeout_ticks(1), "R6 prescaler sel1 time-out", t, timeout_ticks(1));
    measure_pulse(n);
    chk(n == PLEN, "R7 pulse length fourth", n, PLEN);
    chk(rst_req_n == 1'b1, "R8 released after pulse", int'(rst_req_n), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule